// File: doc/BRIEF.md
# Multiframe Auxiliary Channel Controller

This block carries a slow auxiliary code, one bit per selected frame, across the multiframes of a framed line interface. A framer upstream supplies a per-frame strobe, a flag marking the first frame of each multiframe, and the received auxiliary bit. In each multiframe the block collects a 4-bit receive code. A changed receive code is committed and flagged to the host. In the other direction, the block sends out a 4-bit transmit code that the host loads through a small synchronous register port.

Transmit codes are double-buffered. The host writes a holding register. At every multiframe start the holding value moves into a shadow register, and the block raises a transmit-writable flag that invites the next write. A write made before a multiframe start is sent in that multiframe. A write made after it is sent one multiframe later.

Four sticky status flags share one interrupt line under a mask: transmit-writable, receive-code change, and two external line events.

Top module: `mf_aux_ctrl`

## Requirements
- R1: After reset:
  - the receive code register (address 0) reads 0x00;
  - the status register (address 2) reads 0x00;
  - the mask register (address 3) reads 0xFF;
  - `irq_o` and `tx_bit_o` are 0.
- R2: A multiframe is 20 frames long, and the frame with `mf_start_i` high is frame 1.
  - The receive bit is sampled on the strobes of frames 1, 6, 11 and 16, most significant bit first.
  - The collected code is committed on the next multiframe-start strobe.
  - The receive code register does not change at any other time.
  - No commit happens until a full multiframe has been collected after reset.
- R3: When the committed code differs from the stored code, status bit 1 (change) is set. When it is equal, the register and bit 1 are left as they are.
- R4: A host read of address 0 clears status bit 1, unless a differing commit happens in the same cycle.
- R5: Status bit 0 (transmit-writable) is set on every multiframe-start strobe. A host write to address 1 (transmit code, low 4 bits) clears it.
- R6: Transmit code timing:
  - The code in the holding register at a multiframe-start strobe is sent in that multiframe, on frames 1, 6, 11 and 16, most significant bit first.
  - `tx_bit_o` changes one clock after each of those strobes and is stable otherwise.
  - When no new write has been made, the previous code is repeated.
- R7: The change bit and the writable bit can be set in the same cycle, and both are kept.
- R8: Interrupt status and mask:
  - Status bits are: 3 = loss of signal, 2 = line-state change, 1 = code change, 0 = transmit-writable.
  - A 0 in the matching mask bit enables a source.
  - `irq_o` is the OR of the set status bits whose mask bit is 0.
- R9: A pulse on `los_evt_i` sets status bit 3, and a pulse on `lsc_evt_i` sets status bit 2. Both bits stay set until the host reads address 2, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_stb_i | input | 1 | One-cycle pulse per line frame |
| mf_start_i | input | 1 | Marks the strobe of frame 1 of a multiframe |
| rx_bit_i | input | 1 | Received auxiliary bit, valid with the strobe |
| tx_bit_o | output | 1 | Transmitted auxiliary bit |
| los_evt_i | input | 1 | Loss-of-signal event pulse |
| lsc_evt_i | input | 1 | Line-state change event pulse |
| reg_we_i | input | 1 | Register write enable |
| reg_re_i | input | 1 | Register read strobe (read side effects) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from address) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is one multiframe-start strobe that does three things at once:
- commits a changed receive code;
- sets the writable flag;
- selects which host write is sent.

The bench reaches it by driving a whole series of multiframes from a vector table. Each row sets a receive code, whether a transmit write is made, and whether that write lands before or after the start strobe.

After each start strobe, the bench checks the following:
- both status bits are present together;
- the committed code is the previous row's code;
- reading the receive code clears only the change bit.

The transmit bits are collected frame by frame and compared with a model of the holding register.

// File: rtl/mf_aux_pkg.sv
package mf_aux_pkg;
  typedef enum logic [1:0] {
    ADDR_RXC  = 2'd0,
    ADDR_TXC  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_MASK = 2'd3
  } reg_addr_e;

  localparam int unsigned ST_WR  = 0;
  localparam int unsigned ST_CHG = 1;
  localparam int unsigned ST_LSC = 2;
  localparam int unsigned ST_LOS = 3;
  localparam int unsigned ST_W   = 4;
endpackage

// File: rtl/mf_aux_timer.sv
module mf_aux_timer #(
  parameter int unsigned MF_LEN   = 20,
  parameter int unsigned SLOT_GAP = 5,
  parameter int unsigned CODE_W   = 4,
  localparam int unsigned CW = $clog2(MF_LEN),
  localparam int unsigned IW = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_stb_i,
  input  logic          mf_start_i,
  output logic          mf_hit_o,
  output logic          slot_hit_o,
  output logic [IW-1:0] slot_idx_o
);
  logic [CW-1:0] cnt_q, cur;
  logic          seen_q;

  always_comb begin
    if (mf_start_i)                    cur = '0;
    else if (cnt_q == CW'(MF_LEN - 1)) cur = cnt_q;
    else                               cur = cnt_q + 1'b1;
  end

  assign mf_hit_o   = frame_stb_i && mf_start_i;
  assign slot_hit_o = frame_stb_i && (mf_start_i || seen_q) &&
                      ((cur % CW'(SLOT_GAP)) == '0) &&
                      ((cur / CW'(SLOT_GAP)) < CW'(CODE_W));
  assign slot_idx_o = IW'(cur / CW'(SLOT_GAP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(MF_LEN - 1);
      seen_q <= 1'b0;
    end else if (frame_stb_i) begin
      cnt_q  <= cur;
      seen_q <= seen_q | mf_start_i;
    end
  end
endmodule

// File: rtl/mf_aux_rx.sv
module mf_aux_rx #(
  parameter int unsigned CODE_W = 4,
  localparam int unsigned IW = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mf_hit_i,
  input  logic              slot_hit_i,
  input  logic [IW-1:0]     slot_idx_i,
  input  logic              rx_bit_i,
  output logic [CODE_W-1:0] code_o,
  output logic              commit_o,
  output logic              diff_o
);
  logic [CODE_W-1:0] sr_q;
  logic              full_q;

  assign commit_o = mf_hit_i && full_q;
  assign diff_o   = commit_o && (sr_q != code_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      full_q <= 1'b0;
      code_o <= '0;
    end else begin
      if (diff_o) code_o <= sr_q;
      if (slot_hit_i) sr_q <= {sr_q[CODE_W-2:0], rx_bit_i};
      if (slot_hit_i && slot_idx_i == IW'(CODE_W - 1)) full_q <= 1'b1;
      else if (mf_hit_i)                               full_q <= 1'b0;
    end
  end

  assert_code_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |=> $stable(code_o));
endmodule

// File: rtl/mf_aux_tx.sv
module mf_aux_tx #(
  parameter int unsigned CODE_W = 4,
  localparam int unsigned IW = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mf_hit_i,
  input  logic              slot_hit_i,
  input  logic [IW-1:0]     slot_idx_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic [CODE_W-1:0] hold_o,
  output logic              tx_bit_o
);
  logic [CODE_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o   <= '0;
      shadow_q <= '0;
      tx_bit_o <= 1'b0;
    end else begin
      if (wr_i)     hold_o   <= wdata_i;
      if (mf_hit_i) shadow_q <= hold_o;
      if (slot_hit_i) begin
        // first slot coincides with the shadow load: take the holding value
        if (slot_idx_i == '0) tx_bit_o <= hold_o[CODE_W-1];
        else                  tx_bit_o <= shadow_q[IW'(CODE_W - 1) - slot_idx_i];
      end
    end
  end

  assert_tx_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_hit_i |=> $stable(tx_bit_o));
endmodule

// File: rtl/mf_aux_regs.sv
module mf_aux_regs
  import mf_aux_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mf_hit_i,
  input  logic              diff_i,
  input  logic              los_i,
  input  logic              lsc_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [CODE_W-1:0] rx_code_i,
  input  logic [CODE_W-1:0] tx_hold_i,
  output logic              txc_we_o,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  logic [ST_W-1:0] stat_q, stat_d;
  logic [DW-1:0]   mask_q;
  logic            rxc_rd, stat_rd;

  assign txc_we_o = we_i && (addr_i == ADDR_TXC);
  assign rxc_rd   = re_i && (addr_i == ADDR_RXC);
  assign stat_rd  = re_i && (addr_i == ADDR_STAT);

  always_comb begin
    stat_d[ST_WR]  = mf_hit_i | (stat_q[ST_WR]  & ~txc_we_o);
    stat_d[ST_CHG] = diff_i   | (stat_q[ST_CHG] & ~rxc_rd);
    stat_d[ST_LSC] = lsc_i    | (stat_q[ST_LSC] & ~stat_rd);
    stat_d[ST_LOS] = los_i    | (stat_q[ST_LOS] & ~stat_rd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= stat_d;
      if (we_i && addr_i == ADDR_MASK) mask_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_RXC:  rdata_o = DW'(rx_code_i);
      ADDR_TXC:  rdata_o = DW'(tx_hold_i);
      ADDR_STAT: rdata_o = DW'(stat_q);
      default:   rdata_o = mask_q;
    endcase
  end

  assign irq_o = |(stat_q & ~mask_q[ST_W-1:0]);

  assert_wr_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_hit_i |=> stat_q[ST_WR]);
  assert_chg_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxc_rd && !diff_i) |=> !stat_q[ST_CHG]);
  assert_both_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diff_i && mf_hit_i) |=> (stat_q[ST_CHG] && stat_q[ST_WR]));
  assert_los_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[ST_LOS] && !stat_rd) |=> stat_q[ST_LOS]);
endmodule

// File: rtl/mf_aux_ctrl.sv
module mf_aux_ctrl #(
  parameter int unsigned MF_LEN   = 20,
  parameter int unsigned SLOT_GAP = 5,
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned DW       = 8,
  localparam int unsigned IW = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_stb_i,
  input  logic          mf_start_i,
  input  logic          rx_bit_i,
  output logic          tx_bit_o,
  input  logic          los_evt_i,
  input  logic          lsc_evt_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic              mf_hit, slot_hit, commit, diff, txc_we;
  logic [IW-1:0]     slot_idx;
  logic [CODE_W-1:0] rx_code, tx_hold;

  mf_aux_timer #(.MF_LEN(MF_LEN), .SLOT_GAP(SLOT_GAP), .CODE_W(CODE_W)) u_timer (
    .clk_i, .rst_ni, .frame_stb_i, .mf_start_i,
    .mf_hit_o(mf_hit), .slot_hit_o(slot_hit), .slot_idx_o(slot_idx)
  );

  mf_aux_rx #(.CODE_W(CODE_W)) u_rx (
    .clk_i, .rst_ni, .mf_hit_i(mf_hit), .slot_hit_i(slot_hit),
    .slot_idx_i(slot_idx), .rx_bit_i, .code_o(rx_code),
    .commit_o(commit), .diff_o(diff)
  );

  mf_aux_tx #(.CODE_W(CODE_W)) u_tx (
    .clk_i, .rst_ni, .mf_hit_i(mf_hit), .slot_hit_i(slot_hit),
    .slot_idx_i(slot_idx), .wr_i(txc_we), .wdata_i(reg_wdata_i[CODE_W-1:0]),
    .hold_o(tx_hold), .tx_bit_o
  );

  mf_aux_regs #(.CODE_W(CODE_W), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .mf_hit_i(mf_hit), .diff_i(diff),
    .los_i(los_evt_i), .lsc_i(lsc_evt_i), .we_i(reg_we_i), .re_i(reg_re_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rx_code_i(rx_code),
    .tx_hold_i(tx_hold), .txc_we_o(txc_we), .rdata_o(reg_rdata_o), .irq_o
  );

  assert_commit_at_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> mf_start_i);
endmodule

// File: tb/sim_mf_aux_ctrl.sv
module sim_mf_aux_ctrl;
  logic       clk = 0, rst_n = 0;
  logic       stb = 0, mfs = 0, rxb = 0, los = 0, lsc = 0, we = 0, re = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic       txb, irq;
  logic [7:0] rdata;
  int         n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  mf_aux_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_stb_i(stb), .mf_start_i(mfs),
    .rx_bit_i(rxb), .tx_bit_o(txb), .los_evt_i(los), .lsc_evt_i(lsc),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {rx[10:7], tx[6:3], wr_en[2], before[1], chg_exp[0]}
  localparam int NV = 6;
  localparam logic [10:0] VEC [NV] = '{
    {4'hA, 4'h5, 1'b1, 1'b1, 1'b1},
    {4'hA, 4'h3, 1'b1, 1'b0, 1'b0},
    {4'h6, 4'hC, 1'b1, 1'b1, 1'b1},
    {4'h6, 4'h0, 1'b0, 1'b0, 1'b0},
    {4'h9, 4'hF, 1'b1, 1'b0, 1'b1},
    {4'h9, 4'h0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1; #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic frame(input logic start, input logic bitv, output logic tb_o);
    @(negedge clk); stb = 1; mfs = start; rxb = bitv;
    @(negedge clk); stb = 0; mfs = 0; tb_o = txb;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [3:0] hold_m, sent, got, rxc;
    logic       t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check("R1 tx_bit", txb, 0);
    check("R1 irq", irq, 0);
    rd(2'd0, d); check("R1 rxcode", d, 8'h00);
    rd(2'd2, d); check("R1 status", d, 8'h00);
    rd(2'd3, d); check("R1 mask", d, 8'hFF);

    hold_m = 0;
    for (int i = 0; i <= NV; i++) begin
      logic [10:0] v;
      v = (i < NV) ? VEC[i] : 11'h0;
      rxc = v[10:7];
      if (i < NV && v[2] && v[1]) begin
        wr(2'd1, {4'h0, v[6:3]});
        hold_m = v[6:3];
        rd(2'd2, d); check("R5 wr cleared by write", d[0], 0);
      end
      sent = hold_m;
      frame(1'b1, (i < NV) ? rxc[3] : 1'b0, t);
      got[3] = t;
      rd(2'd2, d);
      check("R5 wr set at start", d[0], 1);
      if (i > 0) begin
        check("R7 chg with wr", d[1], int'(VEC[i-1][0]));
        rd(2'd0, d); check("R3 rxcode", d, {4'h0, VEC[i-1][10:7]});
        rd(2'd2, d); check("R4 chg cleared", d[1:0], 2'b01);
      end else begin
        check("R2 no commit before full mf", d[1], 0);
      end
      if (i == NV) break;
      if (v[2] && !v[1]) begin
        wr(2'd1, {4'h0, v[6:3]});
        hold_m = v[6:3];
        rd(2'd2, d); check("R5 wr cleared by write", d[0], 0);
      end
      for (int f = 1; f < 20; f++) begin
        frame(1'b0, (f % 5 == 0) ? rxc[3 - f/5] : 1'b0, t);
        if (f % 5 == 0) got[3 - f/5] = t;
        if (f == 16) begin
          rd(2'd0, d);
          check("R2 rxcode held until start", d,
                {4'h0, (i > 0) ? VEC[i-1][10:7] : 4'h0});
        end
      end
      check($sformatf("R6 tx code row %0d", i), got, sent);
    end

    // clear everything for interrupt tests
    rd(2'd0, d);
    wr(2'd1, 8'h00);
    rd(2'd2, d);
    check("R8 status clear", d, 8'h00);
    @(negedge clk); los = 1; @(negedge clk); los = 0;
    #1 check("R8 irq masked", irq, 0);
    rd(2'd3, d); check("R9 mask read", d, 8'hFF);
    wr(2'd3, 8'hF7);
    #1 check("R8 irq los enabled", irq, 1);
    rd(2'd2, d); check("R9 los sticky", d, 8'h08);
    #1 check("R9 los cleared by read", irq, 0);
    @(negedge clk); lsc = 1; @(negedge clk); lsc = 0;
    #1 check("R8 irq lsc masked", irq, 0);
    wr(2'd3, 8'hF0);
    #1 check("R8 irq lsc enabled", irq, 1);
    rd(2'd2, d); check("R9 lsc sticky", d, 8'h04);
    rd(2'd2, d); check("R9 lsc cleared", d, 8'h00);
    #1 check("R8 irq idle", irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule